// File: doc/BRIEF.md
# Serial Flash Command Snooper

This block follows the byte stream a quad-capable serial flash controller sends while chip-select is asserted, and tells the surrounding datapath how to handle each byte. The first byte of every chip-select window is taken as a flash opcode. The opcode sets how many following bytes carry the address and how many are dummy bytes. It also sets whether the serial link widens to two or four lines, and whether that happens at once or only after a number of bytes. When the counted bytes are done, the stream enters a data phase. In that phase successive bytes alternate between the two parallel flash buses.

Before the data phase, each byte is mirrored to every bus and only the receive byte of bus 0 is kept. A dummy byte is not shifted normally. It is expanded into 8/width single-transfer clocks, and its receive bits are thrown away. The serial shifter and the FIFOs sit outside this block. They present one byte per `byte_valid` pulse and read the per-byte controls, which are valid in the same cycle as the byte.

Top module: `snoop_tracker`

## Requirements
- R1: After reset, and in the cycle after any cycle with `cs_active` low, `phase` is CMD (0) and `link_width` is 1.
- R2: Opcodes 8'h03, 8'h02, 8'hA2 and 8'h32 are followed by 3 bytes in ADDR (1) and then DATA (3).
- R3: Opcodes 8'h0B, 8'h3B, 8'h6B and 8'hBB are followed by 3 ADDR bytes, then 1 DUMMY (2) byte, then DATA.
- R4: Opcode 8'hEB is followed by a countdown of 6 bytes: the first 4 are ADDR, the last 2 are DUMMY, and DATA follows.
- R5: Any other opcode gives PASS (4) until `cs_active` falls.
- R6: `dummy_clks` equals 8/`link_width` while `phase` is DUMMY, and 0 in every other phase.
- R7: Opcodes 8'hA2 and 8'h3B set width 2, and 8'h32 and 8'h6B set width 4. The new width applies only after a further 3 bytes (page programs) or 4 bytes (output reads) have followed the opcode.
- R8: Opcode 8'hBB sets width 2 and 8'hEB sets width 4, starting with the byte that follows the opcode.
- R9: In DATA, `bus_en` is one-hot: it starts at bus 0 and moves to the next bus with each accepted byte. `rx_keep` equals `bus_en`.
- R10: Outside DATA, `bus_en` is all ones. `rx_keep` is 2'b01, except in DUMMY, where it is 0.
- R11: A cycle with `byte_valid` low changes neither the phase, the width nor the bus selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_active | input | 1 | Chip-select asserted; low restarts the tracker |
| byte_valid | input | 1 | A byte is sent this cycle |
| byte_data | input | 8 | Byte being sent |
| phase | output | 3 | Role of the current byte: 0 CMD, 1 ADDR, 2 DUMMY, 3 DATA, 4 PASS |
| link_width | output | 3 | Active line count: 1, 2 or 4 |
| dummy_clks | output | 4 | Single-transfer clocks for the current dummy byte |
| bus_en | output | NUM_BUS | Buses that send the current byte |
| rx_keep | output | NUM_BUS | Buses whose receive byte is stored |

## Verification
A fixed pass over all nine opcodes and one unknown code separates the three countdown lengths and the dummy placement. It also shows whether each width change is deferred or immediate. Random sessions with random opcodes, lengths and idle gaps catch countdowns that slip when `byte_valid` is low. They also catch deferred width changes that count idle cycles, and lane pointers that keep state from an earlier chip-select window. Sessions that end before the data phase show whether a partly counted state survives the restart.

// File: rtl/snoop_pkg.sv
// Package: shared opcode values, phase codes and the decoded-opcode record
// used by the command snooper modules.
package snoop_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 3;
    localparam int WID_W  = 3;

    localparam logic [BYTE_W-1:0] OPC_READ  = 8'h03;
    localparam logic [BYTE_W-1:0] OPC_PROG  = 8'h02;
    localparam logic [BYTE_W-1:0] OPC_PROG2 = 8'hA2;
    localparam logic [BYTE_W-1:0] OPC_PROG4 = 8'h32;
    localparam logic [BYTE_W-1:0] OPC_FAST  = 8'h0B;
    localparam logic [BYTE_W-1:0] OPC_OUT2  = 8'h3B;
    localparam logic [BYTE_W-1:0] OPC_OUT4  = 8'h6B;
    localparam logic [BYTE_W-1:0] OPC_IO2   = 8'hBB;
    localparam logic [BYTE_W-1:0] OPC_IO4   = 8'hEB;

    localparam logic [WID_W-1:0] LINK_X1 = 3'd1;
    localparam logic [WID_W-1:0] LINK_X2 = 3'd2;
    localparam logic [WID_W-1:0] LINK_X4 = 3'd4;

    typedef enum logic [2:0] {
        PH_CMD   = 3'd0,
        PH_ADDR  = 3'd1,
        PH_DUMMY = 3'd2,
        PH_DATA  = 3'd3,
        PH_PASS  = 3'd4
    } phase_e;

    typedef enum logic [1:0] {
        WM_KEEP  = 2'd0,
        WM_LATER = 2'd1,
        WM_NOW   = 2'd2
    } wmode_e;

    typedef struct packed {
        logic              known;
        logic [CNT_W-1:0]  span;
        logic [1:0]        dummies;
        wmode_e            wmode;
        logic [WID_W-1:0]  wval;
    } op_info_t;

endpackage

// File: rtl/snoop_opdec.sv
// Opcode decoder: maps a command byte to its countdown length, the number of
// dummy bytes at the end of that countdown, and the link-width action.
// Assumes: purely combinational, byte taken only when the tracker waits.
module snoop_opdec
    import snoop_pkg::*;
(
    input  logic [BYTE_W-1:0] opcode,
    output op_info_t          info
);

    // Table lookup of the opcode properties
    always_comb begin
        info         = '0;
        info.known   = 1'b1;
        info.wmode   = WM_KEEP;
        info.wval    = LINK_X1;
        unique case (opcode)
            OPC_READ, OPC_PROG: begin
                info.span = 3'd3;
            end
            OPC_PROG2: begin
                info.span  = 3'd3;
                info.wmode = WM_LATER;
                info.wval  = LINK_X2;
            end
            OPC_PROG4: begin
                info.span  = 3'd3;
                info.wmode = WM_LATER;
                info.wval  = LINK_X4;
            end
            OPC_FAST: begin
                info.span    = 3'd4;
                info.dummies = 2'd1;
            end
            OPC_OUT2: begin
                info.span    = 3'd4;
                info.dummies = 2'd1;
                info.wmode   = WM_LATER;
                info.wval    = LINK_X2;
            end
            OPC_OUT4: begin
                info.span    = 3'd4;
                info.dummies = 2'd1;
                info.wmode   = WM_LATER;
                info.wval    = LINK_X4;
            end
            OPC_IO2: begin
                info.span    = 3'd4;
                info.dummies = 2'd1;
                info.wmode   = WM_NOW;
                info.wval    = LINK_X2;
            end
            OPC_IO4: begin
                info.span    = 3'd6;
                info.dummies = 2'd2;
                info.wmode   = WM_NOW;
                info.wval    = LINK_X4;
            end
            default: begin
                info.known = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/snoop_phase.sv
// Phase tracker: waits for an opcode, counts address and dummy bytes down,
// then holds the data phase (or pass-through for unknown opcodes) until the
// chip-select window closes.
// Assumes: step is one accepted byte; clear restarts the tracker.
module snoop_phase
    import snoop_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clear,
    input  logic     step,
    input  op_info_t info,
    output phase_e   phase,
    output logic     at_cmd
);

    typedef enum logic [1:0] {
        ST_WAIT   = 2'd0,
        ST_COUNT  = 2'd1,
        ST_STRIPE = 2'd2,
        ST_PASS   = 2'd3
    } st_e;

    st_e              st;
    logic [CNT_W-1:0] left;
    logic [1:0]       dum;

    // State and countdown update per accepted byte
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            st   <= ST_WAIT;
            left <= '0;
            dum  <= '0;
        end else if (step) begin
            unique case (st)
                ST_WAIT: begin
                    if (info.known) begin
                        st   <= ST_COUNT;
                        left <= info.span;
                        dum  <= info.dummies;
                    end else begin
                        st <= ST_PASS;
                    end
                end
                ST_COUNT: begin
                    left <= left - 1'b1;
                    if (left == CNT_W'(1)) begin
                        st <= ST_STRIPE;
                    end
                end
                default: ;
            endcase
        end
    end

    // Role of the byte presented this cycle
    always_comb begin
        unique case (st)
            ST_WAIT:   phase = PH_CMD;
            ST_STRIPE: phase = PH_DATA;
            ST_PASS:   phase = PH_PASS;
            default:   phase = (left <= CNT_W'(dum)) ? PH_DUMMY : PH_ADDR;
        endcase
    end

    assign at_cmd = (st == ST_WAIT);

endmodule

// File: rtl/snoop_width.sv
// Link-width scheduler: holds the active line count, applies immediate
// changes on the opcode byte and deferred changes after a byte countdown.
// Assumes: deferred countdown starts with the byte after the opcode.
module snoop_width
    import snoop_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic             at_cmd,
    input  op_info_t         info,
    output logic [WID_W-1:0] width
);

    logic [WID_W-1:0] pend;
    logic [CNT_W-1:0] wait_cnt;

    // Width, pending width and deferral countdown
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            width    <= LINK_X1;
            pend     <= LINK_X1;
            wait_cnt <= '0;
        end else if (step) begin
            if (wait_cnt != '0) begin
                wait_cnt <= wait_cnt - 1'b1;
                if (wait_cnt == CNT_W'(1)) begin
                    width <= pend;
                end
            end
            if (at_cmd && info.known) begin
                unique case (info.wmode)
                    WM_NOW: width <= info.wval;
                    WM_LATER: begin
                        pend     <= info.wval;
                        wait_cnt <= info.span;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/snoop_lanes.sv
// Lane steering: mirrors bytes to all buses before the data phase, rotates
// a one-hot bus select through the data phase, and sizes dummy bursts.
// Assumes: the rotation pointer is cleared with each chip-select window.
module snoop_lanes
    import snoop_pkg::*;
#(
    parameter int NUM_BUS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               step,
    input  phase_e             phase,
    input  logic [WID_W-1:0]   width,
    output logic [NUM_BUS-1:0] bus_en,
    output logic [NUM_BUS-1:0] rx_keep,
    output logic [3:0]         dummy_clks
);

    localparam int PTR_W = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NUM_BUS - 1);

    logic [PTR_W-1:0] ptr;
    logic             in_data;
    logic             in_dummy;

    assign in_data  = (phase == PH_DATA);
    assign in_dummy = (phase == PH_DUMMY);

    // Rotate the data-phase bus pointer per accepted byte
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            ptr <= '0;
        end else if (step && in_data) begin
            ptr <= (ptr == PTR_LAST) ? '0 : ptr + 1'b1;
        end
    end

    // Per-bus enable and receive-keep flags
    for (genvar g = 0; g < NUM_BUS; g++) begin : g_bus
        assign bus_en[g]  = in_data ? (ptr == PTR_W'(g)) : 1'b1;
        assign rx_keep[g] = in_data ? (ptr == PTR_W'(g))
                                    : (!in_dummy && (g == 0));
    end

    // Dummy burst length: one byte spread over the active lines
    always_comb begin
        dummy_clks = 4'd0;
        if (in_dummy) begin
            unique case (width)
                LINK_X2: dummy_clks = 4'd4;
                LINK_X4: dummy_clks = 4'd2;
                default: dummy_clks = 4'd8;
            endcase
        end
    end

endmodule

// File: rtl/snoop_tracker.sv
// Top: flash command snooper. Accepts one byte per byte_valid while
// cs_active is high; cs_active low restarts decode at the next byte.
// Assumes: outputs describe the byte presented in the same cycle.
module snoop_tracker
    import snoop_pkg::*;
#(
    parameter int NUM_BUS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_active,
    input  logic               byte_valid,
    input  logic [7:0]         byte_data,
    output logic [2:0]         phase,
    output logic [2:0]         link_width,
    output logic [3:0]         dummy_clks,
    output logic [NUM_BUS-1:0] bus_en,
    output logic [NUM_BUS-1:0] rx_keep
);

    logic     clear;
    logic     step;
    logic     at_cmd;
    op_info_t info;
    phase_e   ph;

    assign clear = !cs_active;
    assign step  = cs_active && byte_valid;

    snoop_opdec u_dec (
        .opcode (byte_data),
        .info   (info)
    );

    snoop_phase u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clear),
        .step   (step),
        .info   (info),
        .phase  (ph),
        .at_cmd (at_cmd)
    );

    snoop_width u_width (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clear),
        .step   (step),
        .at_cmd (at_cmd),
        .info   (info),
        .width  (link_width)
    );

    snoop_lanes #(.NUM_BUS(NUM_BUS)) u_lanes (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .step       (step),
        .phase      (ph),
        .width      (link_width),
        .bus_en     (bus_en),
        .rx_keep    (rx_keep),
        .dummy_clks (dummy_clks)
    );

    assign phase = ph;

endmodule

// File: rtl/snoop_checker.sv
// Checker: temporal properties of the snooper ports, bound to the top.
module snoop_checker #(
    parameter int NUM_BUS = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cs_active,
    input logic               byte_valid,
    input logic [2:0]         phase,
    input logic [2:0]         link_width,
    input logic [3:0]         dummy_clks,
    input logic [NUM_BUS-1:0] bus_en,
    input logic [NUM_BUS-1:0] rx_keep
);

    assert_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_active |=> (phase == 3'd0 && link_width == 3'd1));

    assert_pass_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd4 && cs_active) |=> phase == 3'd4);

    assert_dummy_burst_R6: assert property (@(posedge clk) disable iff (!rst_n)
        phase == 3'd2 |-> (7'(dummy_clks) * 7'(link_width)) == 7'd8);

    assert_no_burst_R6: assert property (@(posedge clk) disable iff (!rst_n)
        phase != 3'd2 |-> dummy_clks == 4'd0);

    assert_width_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (link_width == 3'd1 || link_width == 3'd2 || link_width == 3'd4));

    assert_data_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        phase == 3'd3 |-> ($onehot(bus_en) && rx_keep == bus_en));

    assert_data_rotates_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd3 && cs_active && byte_valid) |=> bus_en != $past(bus_en));

    assert_data_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd3 && cs_active) |=> phase == 3'd3);

    assert_mirror_R10: assert property (@(posedge clk) disable iff (!rst_n)
        phase != 3'd3 |-> &bus_en);

    assert_keep_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != 3'd3 && phase != 3'd2) |-> rx_keep == NUM_BUS'(1));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_active && !byte_valid) |=>
            ($stable(phase) && $stable(link_width) && $stable(bus_en)));

endmodule

bind snoop_tracker snoop_checker #(.NUM_BUS(NUM_BUS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_active  (cs_active),
    .byte_valid (byte_valid),
    .phase      (phase),
    .link_width (link_width),
    .dummy_clks (dummy_clks),
    .bus_en     (bus_en),
    .rx_keep    (rx_keep)
);

// File: tb/test_snoop_tracker.sv
`timescale 1ns/1ps
module test_snoop_tracker;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_active = 1'b1;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic [2:0] phase;
    logic [2:0] link_width;
    logic [3:0] dummy_clks;
    logic [1:0] bus_en;
    logic [1:0] rx_keep;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // bench model: -1 wait, -2 pass, 0 data, >0 countdown
    int m_st = -1, m_dum = 0, m_w = 1, m_next = 1, m_when = 0, m_ptr = 0;
    string ptag = "R1";
    string wtag = "R1";
    bit last_idle = 1'b0;

    always #2.5 clk = ~clk;

    snoop_tracker #(.NUM_BUS(2)) i_snoop_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_active  (cs_active),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .phase      (phase),
        .link_width (link_width),
        .dummy_clks (dummy_clks),
        .bus_en     (bus_en),
        .rx_keep    (rx_keep)
    );

    function automatic int exp_phase();
        if (m_st == -1) return 0;
        if (m_st == -2) return 4;
        if (m_st == 0)  return 3;
        return (m_st <= m_dum) ? 2 : 1;
    endfunction

    function automatic int exp_dclk();
        return (exp_phase() == 2) ? 8 / m_w : 0;
    endfunction

    function automatic int exp_bus();
        return (exp_phase() == 3) ? (1 << m_ptr) : 3;
    endfunction

    function automatic int exp_keep();
        if (exp_phase() == 3) return 1 << m_ptr;
        return (exp_phase() == 2) ? 0 : 1;
    endfunction

    task automatic cmp(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all();
        string lt;
        lt = (exp_phase() == 3) ? "R9" : "R10";
        cmp(last_idle ? "R11" : ptag, "phase", int'(phase), exp_phase());
        cmp(last_idle ? "R11" : wtag, "width", int'(link_width), m_w);
        cmp("R6", "dummy_clks", int'(dummy_clks), exp_dclk());
        cmp(lt, "bus_en", int'(bus_en), exp_bus());
        cmp(lt, "rx_keep", int'(rx_keep), exp_keep());
    endtask

    task automatic model_decode(int b);
        m_st = 3; m_dum = 0; ptag = "R2"; wtag = "R1";
        case (b)
            8'h03, 8'h02: ;
            8'hA2: begin m_next = 2; m_when = 3; wtag = "R7"; end
            8'h32: begin m_next = 4; m_when = 3; wtag = "R7"; end
            8'h0B: begin m_st = 4; m_dum = 1; ptag = "R3"; end
            8'h3B: begin m_st = 4; m_dum = 1; ptag = "R3"; m_next = 2; m_when = 4; wtag = "R7"; end
            8'h6B: begin m_st = 4; m_dum = 1; ptag = "R3"; m_next = 4; m_when = 4; wtag = "R7"; end
            8'hBB: begin m_st = 4; m_dum = 1; ptag = "R3"; m_w = 2; wtag = "R8"; end
            8'hEB: begin m_st = 6; m_dum = 2; ptag = "R4"; m_w = 4; wtag = "R8"; end
            default: begin m_st = -2; ptag = "R5"; end
        endcase
    endtask

    task automatic model_step(int b);
        if (m_when > 0) begin
            m_when--;
            if (m_when == 0) m_w = m_next;
        end
        if (m_st == -1)      model_decode(b);
        else if (m_st == 0)  m_ptr = (m_ptr + 1) % 2;
        else if (m_st > 0)   m_st--;
    endtask

    task automatic send(int b, bit v);
        @(negedge clk);
        check_all();
        cs_active  = 1'b1;
        byte_valid = v;
        byte_data  = 8'(b);
        @(posedge clk);
        if (v) model_step(b);
        last_idle = !v;
    endtask

    task automatic cs_drop();
        @(negedge clk);
        check_all();
        cs_active  = 1'b0;
        byte_valid = 1'b0;
        @(posedge clk);
        m_st = -1; m_dum = 0; m_w = 1; m_next = 1; m_when = 0; m_ptr = 0;
        ptag = "R1"; wtag = "R1"; last_idle = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    // Stimulus
    initial begin
        int ops[10] = '{8'h03, 8'h02, 8'hA2, 8'h32, 8'h0B, 8'h3B, 8'h6B, 8'hBB, 8'hEB, 8'hFF};
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R1 reset state
        @(negedge clk);
        check_all();
        // directed: each opcode, full length with an idle gap
        foreach (ops[i]) begin
            cs_drop();
            send(ops[i], 1'b1);
            for (int k = 0; k < 9; k++) begin
                send($urandom & 8'hFF, 1'b1);
                if (k == 2) send(8'h5A, 1'b0);
            end
        end
        // random sessions
        for (int s = 0; s < 400; s++) begin
            int len;
            int op;
            cs_drop();
            op  = ($urandom % 4 == 0) ? int'($urandom & 8'hFF) : ops[$urandom % 10];
            len = 1 + $urandom % 14;
            send(op, 1'b1);
            for (int k = 0; k < len; k++) begin
                send($urandom & 8'hFF, ($urandom % 4) != 0);
            end
        end
        @(negedge clk);
        check_all();
        finish_run();
    end

endmodule